// File: doc/BRIEF.md
# Error Interrupt Status Controller

This block collects six error event pulses from a PCIe controller into a sticky raw status register. Software reads the status either unmasked or through a per-source enable mask. It clears the bits it has handled by writing ones. The enable mask is changed only through two write-only strobes, one that sets mask bits and one that clears them, so no read-modify-write is ever needed.

Two interrupt lines leave the block. The first is a combined error interrupt, raised whenever any enabled status bit is set. The second is a fatal indication, raised only by enabled bits of a fixed fatal subset. The sources, by bit index, are:

- bit 0: system error summary
- bit 1: fatal error
- bit 2: non-fatal error
- bit 3: correctable error
- bit 4: interconnect tag lookup fatal error
- bit 5: ECRC error

Bits 1 and 4 form the fatal subset. Register offsets relative to the base address are:

| Offset | Register |
|---|---|
| 0x0 | raw status |
| 0x4 | masked status |
| 0x8 | enable-set |
| 0xC | enable-clear |

The default base is 0x1C0, so the registers sit at 0x1C0, 0x1C4, 0x1C8 and 0x1CC.

Top module: `eirq_ctrl`

## Requirements
- R1: A one-cycle high pulse on bit i of `evt_i` makes raw status bit i read as 1 from the clock edge that samples the pulse onward.
- R2: A write to the raw status offset (0x1C0) or the masked status offset (0x1C4) clears every status bit whose write data bit is 1. Bits written as 0 keep their value.
- R3: When an event pulse and a clearing write hit the same status bit at the same edge, the bit ends up set.
- R4: Writing to enable-set (0x1C8) sets the enable bits written as 1. Writing to enable-clear (0x1CC) clears the enable bits written as 1. Reading either offset returns the current enable mask.
- R5: A read of 0x1C0 returns the raw status. A read of 0x1C4 returns raw status AND enable.
- R6: `irq_o` is high exactly when the masked status is nonzero.
- R7: `fatal_o` is high exactly when masked status bit 1 or bit 4 is set. Whenever `fatal_o` is high, `irq_o` is also high.
- R8: After reset, all status bits and all enable bits are 0, and both outputs are low.
- R9: Write data bits 31 to 6 have no effect and always read as 0. Reads of unmapped offsets return 0, and writes to unmapped offsets change nothing.
- R10: Events latch into raw status regardless of the enable mask. A bit already pending raises `irq_o` as soon as its enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 6 | Error event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from `addr` |
| irq_o | output | 1 | Combined error interrupt |
| fatal_o | output | 1 | Fatal-class error interrupt |

## Verification
The bench builds the block with its default parameters: six sources, fatal mask 6'b010010 and base address 0x1C0.

This puts every source bit, both members of the fatal subset and every mapped offset within reach, along with unmapped neighbours just past the window. The same-edge event-versus-clear collision is driven on both a pending bit and an idle bit. Pending-before-enable ordering is exercised in both directions.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    // Register offsets relative to the block base address
    localparam int OFS_RAW   = 'h0;
    localparam int OFS_MASKD = 'h4;
    localparam int OFS_ENSET = 'h8;
    localparam int OFS_ENCLR = 'hC;

    // Decoded write strobes
    typedef struct packed {
        logic st_clr;
        logic en_set;
        logic en_clr;
    } eirq_wstb_t;

endpackage

// File: rtl/eirq_status_bank.sv
module eirq_status_bank #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               clr_stb,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] raw
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic sticky_q;

        // Event set outranks a clearing write on the same edge
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sticky_q <= 1'b0;
            end else if (evt[i]) begin
                sticky_q <= 1'b1;
            end else if (clr_stb && clr_mask[i]) begin
                sticky_q <= 1'b0;
            end
        end

        assign raw[i] = sticky_q;
    end

endmodule

// File: rtl/eirq_enable_reg.sv
module eirq_enable_reg #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_stb,
    input  logic               clr_stb,
    input  logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] en
);

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (set_stb) begin
            en_d = en_d | mask;
        end
        if (clr_stb) begin
            en_d = en_d & ~mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign en = en_q;

endmodule

// File: rtl/eirq_reg_decode.sv
module eirq_reg_decode
    import eirq_pkg::*;
#(
    parameter int                 NUM_SRC   = 6,
    parameter int                 ADDR_W    = 12,
    parameter int                 DATA_W    = 32,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 12'h1C0
) (
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SRC-1:0] raw,
    input  logic [NUM_SRC-1:0] masked,
    input  logic [NUM_SRC-1:0] en,
    output eirq_wstb_t         wstb,
    output logic [NUM_SRC-1:0] wmask,
    output logic [DATA_W-1:0]  rdata
);

    localparam logic [ADDR_W-1:0] A_RAW   = BASE_ADDR + ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_MASKD = BASE_ADDR + ADDR_W'(OFS_MASKD);
    localparam logic [ADDR_W-1:0] A_ENSET = BASE_ADDR + ADDR_W'(OFS_ENSET);
    localparam logic [ADDR_W-1:0] A_ENCLR = BASE_ADDR + ADDR_W'(OFS_ENCLR);

    logic hit_raw, hit_maskd, hit_enset, hit_enclr;

    assign hit_raw   = (addr == A_RAW);
    assign hit_maskd = (addr == A_MASKD);
    assign hit_enset = (addr == A_ENSET);
    assign hit_enclr = (addr == A_ENCLR);

    // Only the implemented low bits of write data are used
    assign wmask = wdata[NUM_SRC-1:0];

    always_comb begin
        wstb.st_clr = wr_en && (hit_raw || hit_maskd);
        wstb.en_set = wr_en && hit_enset;
        wstb.en_clr = wr_en && hit_enclr;
    end

    always_comb begin
        rdata = '0;
        if (hit_raw) begin
            rdata[NUM_SRC-1:0] = raw;
        end else if (hit_maskd) begin
            rdata[NUM_SRC-1:0] = masked;
        end else if (hit_enset || hit_enclr) begin
            rdata[NUM_SRC-1:0] = en;
        end
    end

endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
    import eirq_pkg::*;
#(
    parameter int                 NUM_SRC    = 6,
    parameter int                 ADDR_W     = 12,
    parameter int                 DATA_W     = 32,
    parameter logic [ADDR_W-1:0]  BASE_ADDR  = 12'h1C0,
    parameter logic [NUM_SRC-1:0] FATAL_MASK = 6'b010010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_o,
    output logic               fatal_o
);

    eirq_wstb_t         wstb;
    logic [NUM_SRC-1:0] wmask;
    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] masked;

    eirq_reg_decode #(
        .NUM_SRC   (NUM_SRC),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_dec (
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .raw    (raw_q),
        .masked (masked),
        .en     (en_q),
        .wstb   (wstb),
        .wmask  (wmask),
        .rdata  (rdata)
    );

    eirq_status_bank #(
        .NUM_SRC (NUM_SRC)
    ) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_i),
        .clr_stb  (wstb.st_clr),
        .clr_mask (wmask),
        .raw      (raw_q)
    );

    eirq_enable_reg #(
        .NUM_SRC (NUM_SRC)
    ) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (wstb.en_set),
        .clr_stb (wstb.en_clr),
        .mask    (wmask),
        .en      (en_q)
    );

    assign masked  = raw_q & en_q;
    assign irq_o   = |masked;
    assign fatal_o = |(masked & FATAL_MASK);

endmodule

// File: rtl/eirq_chk.sv
module eirq_chk #(
    parameter int NUM_SRC = 6,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               wr_en,
    input logic [DATA_W-1:0]  rdata,
    input logic [NUM_SRC-1:0] raw,
    input logic [NUM_SRC-1:0] en,
    input logic               irq_o,
    input logic               fatal_o
);

    // R1 / R3: a sampled event always leaves its bit set, even under a clear
    a_r1_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((raw & $past(evt_i)) == $past(evt_i)));

    // R2: without a write, no status bit can fall
    a_r2_no_clear_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((raw & $past(raw)) == $past(raw)));

    // R4: enable mask moves only on writes
    a_r4_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en));

    // R6: an enabled pending bit raises the interrupt
    a_r6_irq_on_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (|(raw & en)) |-> irq_o);

    // R7: fatal is a subset of the combined interrupt
    a_r7_fatal_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |-> irq_o);

    // R9: unimplemented read bits are zero
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata >> NUM_SRC) == '0);

endmodule

bind eirq_ctrl eirq_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .wr_en   (wr_en),
    .rdata   (rdata),
    .raw     (raw_q),
    .en      (en_q),
    .irq_o   (irq_o),
    .fatal_o (fatal_o)
);

// File: tb/sim_eirq_ctrl.sv
module sim_eirq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_RAW = 12'h1C0;
    localparam logic [11:0] A_MSK = 12'h1C4;
    localparam logic [11:0] A_SET = 12'h1C8;
    localparam logic [11:0] A_CLR = 12'h1CC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  evt_i = '0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o;
    logic        fatal_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [5:0] m_raw = '0;
    logic [5:0] m_en  = '0;

    // Scoreboard queues: kind 0 = rdata, 1 = irq_o, 2 = fatal_o
    int          q_kind[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    eirq_ctrl u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq_o   (irq_o),
        .fatal_o (fatal_o)
    );

    // Monitor: compares queued expectations a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            while (q_exp.size() > 0) begin
                int          k;
                logic [31:0] e;
                logic [31:0] a;
                string       t;
                k = q_kind.pop_front();
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                a = (k == 0) ? rdata : (k == 1) ? {31'b0, irq_o} : {31'b0, fatal_o};
                total++;
                if (a !== e) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [11:0] a);
        case (a)
            A_RAW:        return {26'b0, m_raw};
            A_MSK:        return {26'b0, m_raw & m_en};
            A_SET, A_CLR: return {26'b0, m_en};
            default:      return '0;
        endcase
    endfunction

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0;
        evt_i = '0;
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        @(negedge clk);
        wr_en = 1'b0;
        evt_i = '0;
        addr  = a;
        q_kind.push_back(0);
        q_exp.push_back(model_read(a));
        q_tag.push_back(tag);
    endtask

    task automatic pins(input string tag);
        @(negedge clk);
        wr_en = 1'b0;
        evt_i = '0;
        q_kind.push_back(1);
        q_exp.push_back({31'b0, |(m_raw & m_en)});
        q_tag.push_back(tag);
        q_kind.push_back(2);
        q_exp.push_back({31'b0, |(m_raw & m_en & 6'b010010)});
        q_tag.push_back(tag);
    endtask

    // Write with optional same-edge event pulse
    task automatic wr_evt(input logic [11:0] a, input logic [31:0] d, input logic [5:0] ev);
        logic [5:0] clr;
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        evt_i = ev;
        clr = ((a == A_RAW) || (a == A_MSK)) ? d[5:0] : 6'b0;
        m_raw = (m_raw & ~clr) | ev;
        if (a == A_SET) m_en = m_en | d[5:0];
        if (a == A_CLR) m_en = m_en & ~d[5:0];
        @(negedge clk);
        wr_en = 1'b0;
        evt_i = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_evt(a, d, 6'b0);
    endtask

    task automatic pulse(input logic [5:0] ev);
        @(negedge clk);
        wr_en = 1'b0;
        evt_i = ev;
        m_raw = m_raw | ev;
        @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state
        rd(A_RAW, "R8 raw after reset");
        rd(A_MSK, "R8 masked after reset");
        rd(A_SET, "R8 enable after reset");
        pins("R8 outputs after reset");

        // R1 / R10: disabled event still latches
        pulse(6'b001000);
        rd(A_RAW, "R1 raw after correctable event");
        rd(A_MSK, "R5 masked while disabled");
        pins("R10 no irq while disabled");

        // R10 / R4 / R6: enabling a pending bit raises irq
        wr(A_SET, 32'h0000_0008);
        rd(A_SET, "R4 enable via set offset");
        rd(A_CLR, "R4 enable via clear offset");
        rd(A_MSK, "R5 masked after enable");
        pins("R6 irq after enabling pending bit");

        // R7: fatal bit 1
        pulse(6'b000010);
        pins("R7 fatal bit pending but disabled");
        wr(A_SET, 32'h0000_0002);
        pins("R7 fatal after enabling bit 1");

        // R9: upper bits and unmapped offsets
        wr(A_SET, 32'hFFFF_FFC0);
        rd(A_SET, "R9 upper write bits ignored");
        wr(12'h1D0, 32'hFFFF_FFFF);
        rd(12'h1D0, "R9 unmapped read zero");
        rd(A_RAW, "R9 unmapped write no effect");
        wr(A_RAW, 32'hFFFF_FFC0);
        rd(A_RAW, "R9 upper clear bits ignored");

        // R2: W1C through both status offsets
        wr(A_RAW, 32'h0000_0008);
        rd(A_RAW, "R2 clear via raw offset");
        pins("R2 outputs after partial clear");
        wr(A_MSK, 32'h0000_0002);
        rd(A_RAW, "R2 clear via masked offset");
        pins("R2 outputs after full clear");

        // R7: bit 4 fatal member
        wr(A_SET, 32'h0000_003F);
        pulse(6'b010000);
        pins("R7 fatal from bit 4");
        wr(A_RAW, 32'h0000_0010);

        // R3: event and clear at the same edge
        pulse(6'b100000);
        wr_evt(A_RAW, 32'h0000_0021, 6'b100001);
        rd(A_RAW, "R3 set wins over clear");
        pins("R3 outputs after collision");

        // R4: enable-clear masks bit 5
        wr(A_CLR, 32'h0000_0021);
        rd(A_CLR, "R4 enable after clear");
        rd(A_MSK, "R5 masked after enable clear");
        pins("R6 irq low once masked");
        wr(A_RAW, 32'h0000_003F);

        // R1: each source bit on its own
        wr(A_SET, 32'h0000_003F);
        for (int i = 0; i < 6; i++) begin
            pulse(6'(1 << i));
            rd(A_RAW, "R1 single source bit");
            pins("R7 per-bit fatal decode");
            wr(A_MSK, 32'(1 << i));
            rd(A_RAW, "R2 single bit cleared");
        end

        idle();
        idle();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule